// File: doc/BRIEF.md
# Paired-Compare Set/Clear Waveform Timer

A single up-counting base timer is shared by a group of output channels. Each channel owns two compare registers. When the timer reaches the first value the channel output leaves its resting level. When it reaches the second value the output goes back. One pulse of programmable position and width is therefore produced in every timer period, with a fixed phase relationship between all channels.

The period has three sources. The timer can wrap across its whole range. It can be cleared after it reaches a dedicated period register. It can also be cleared after it reaches the first compare register of channel 0. Both clear modes give a period of the register value plus two, and in the channel-0 mode channel 0 gives up its output. Every compare match sets its own interrupt request flag, and the flag stays set until software writes a 0 to it. Each channel also has an enable bit, a resting-level bit and an output inversion bit.

Software programs the block through a write-only register port. The addresses in the default configuration (CW=16, NPAIR=4) are:

- 0 to 7: compare registers. Channel i uses address 2i for its set value and 2i+1 for its clear value.
- 8: period register.
- 9: control. Bits [1:0] select the timer mode and bit 2 runs the timer.
- 10: channel enables. Bit i controls channel i.
- 11: resting levels. Bit i belongs to channel i.
- 12: inversion. Bit i belongs to channel i.
- 13: flag clear.

Top module: `setclr_wave_timer`

## Requirements
- R1: When the control register at address 9 has bits [1:0]=00 (or 11) and bit 2 set, the timer counts 0 up to 2^CW-1 and wraps, so the waveform repeats every 2^CW clocks. Cycle 0 is the first cycle after the write that sets the run bit.
- R2: For a channel with set value m below clear value n, the internal waveform is active in exactly those cycles where the timer value c satisfies m < c <= n. That is n-m clocks per period.
- R3: With mode bits [1:0]=01 the timer is cleared after it reaches the period register value p (address 8). The values run 0..p+1, so the period is p+2 clocks.
- R4: With mode bits [1:0]=10 the timer is cleared after it reaches channel 0's set value p, giving a period of p+2. In this mode channel 0's internal waveform stays inactive, while channels 1 and up keep working.
- R5: When a channel's set and clear values are equal, both matches fall in the same cycle and its waveform does not change.
- R6: A compare match sets bit i of irq_flag, where i is the compare address. Writing to address 13 clears every flag whose data bit is 0 and leaves every flag whose data bit is 1.
- R7: If a clear write and a match on the same flag fall in the same cycle, the flag ends up set.
- R8: A channel whose enable bit (address 10) is 0 outputs its resting level XOR its inversion bit.
- R9: wave_out[i] equals the internal waveform XOR the resting-level bit (address 11) XOR the inversion bit (address 12). All three are registered, and the output updates on the clock edge that follows the match.
- R10: After reset the timer is stopped, no matches occur, every flag is 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address (AW = clog2(2*NPAIR+6)) |
| wr_data | input | CW | Register write data |
| wave_out | output | NPAIR | Registered channel outputs |
| irq_flag | output | 2*NPAIR | Per-compare interrupt request flags |

## Verification
The assertions assume that software changes neither the mode nor the period source while the timer runs across a clear point. They also assume that the reset is held for at least one clock before the first write. The stimulus only reconfigures the block after it has written the run bit to 0, and it programs compare values no larger than the period minus one, so every match it sets up is reachable. Each sweep follows the waveform through at least two full periods in every timer mode and compares every cycle against c = t mod period. The concurrent clear-and-match case is hit by counting cycles from the run write.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
  typedef enum logic [1:0] {
    RM_FREE     = 2'd0,
    RM_PERIOD   = 2'd1,
    RM_CH0      = 2'd2,
    RM_FREE_ALT = 2'd3
  } rst_mode_e;
endpackage

// File: rtl/sc_regfile.sv
module sc_regfile
  import setclr_pkg::*;
#(
  parameter int CW    = 16,
  parameter int NPAIR = 4,
  localparam int NCMP = 2 * NPAIR,
  localparam int AW   = $clog2(NCMP + 6),
  localparam int IW   = $clog2(NCMP)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [CW-1:0]             wr_data,
  output logic [NCMP-1:0][CW-1:0]   cmp_q,
  output logic [CW-1:0]             per_q,
  output rst_mode_e                 mode_q,
  output logic                      run_q,
  output logic [NPAIR-1:0]          en_q,
  output logic [NPAIR-1:0]          dflt_q,
  output logic [NPAIR-1:0]          inv_q,
  output logic [NCMP-1:0]           clr_mask
);
  localparam int A_PER = NCMP;
  localparam int A_CTL = NCMP + 1;
  localparam int A_EN  = NCMP + 2;
  localparam int A_DFL = NCMP + 3;
  localparam int A_INV = NCMP + 4;
  localparam int A_CLR = NCMP + 5;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      per_q  <= '0;
      mode_q <= RM_FREE;
      run_q  <= 1'b0;
      en_q   <= '0;
      dflt_q <= '0;
      inv_q  <= '0;
    end else if (wr_en) begin
      if (int'(wr_addr) < NCMP)               cmp_q[wr_addr[IW-1:0]] <= wr_data;
      else if (wr_addr == AW'(A_PER))         per_q  <= wr_data;
      else if (wr_addr == AW'(A_CTL)) begin
        mode_q <= rst_mode_e'(wr_data[1:0]);
        run_q  <= wr_data[2];
      end
      else if (wr_addr == AW'(A_EN))          en_q   <= wr_data[NPAIR-1:0];
      else if (wr_addr == AW'(A_DFL))         dflt_q <= wr_data[NPAIR-1:0];
      else if (wr_addr == AW'(A_INV))         inv_q  <= wr_data[NPAIR-1:0];
    end
  end

  // Zero data bits select the flags to drop; one bits leave them alone.
  assign clr_mask = (wr_en && wr_addr == AW'(A_CLR)) ? ~wr_data[NCMP-1:0] : '0;
endmodule

// File: rtl/sc_base_counter.sv
module sc_base_counter
  import setclr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  rst_mode_e     mode,
  input  logic [CW-1:0] per,
  input  logic [CW-1:0] cmp0,
  output logic [CW-1:0] cnt_q
);
  logic          pend_q;
  logic          clr_on;
  logic [CW-1:0] clr_val;

  assign clr_on  = (mode == RM_PERIOD) || (mode == RM_CH0);
  assign clr_val = (mode == RM_CH0) ? cmp0 : per;

  // A match registers a pending clear, so the timer passes through p+1
  // before it returns to zero: period p+2.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= clr_on && (cnt_q == clr_val);
      cnt_q  <= pend_q ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sc_pair_channel.sv
module sc_pair_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic          run,
  input  logic          en,
  input  logic          block,
  input  logic [CW-1:0] cmp_set,
  input  logic [CW-1:0] cmp_clr,
  input  logic          dflt,
  input  logic          inv,
  output logic          hit_set,
  output logic          hit_clr,
  output logic          act_q,
  output logic          pin_q
);
  logic act_nxt;

  assign hit_set = run && (cnt == cmp_set);
  assign hit_clr = run && (cnt == cmp_clr);

  always_comb begin
    if (!(run && en && !block))      act_nxt = 1'b0;
    else if (hit_set && !hit_clr)    act_nxt = 1'b1;
    else if (hit_clr && !hit_set)    act_nxt = 1'b0;
    else                             act_nxt = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      act_q <= act_nxt;
      pin_q <= act_nxt ^ dflt ^ inv;
    end
  end
endmodule

// File: rtl/sc_flag_bank.sv
module sc_flag_bank #(
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] hit,
  input  logic [NF-1:0] clr_mask,
  output logic [NF-1:0] flag_q
);
  // A new match outranks a clear issued in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= hit | (flag_q & ~clr_mask);
  end
endmodule

// File: rtl/setclr_wave_timer.sv
module setclr_wave_timer
  import setclr_pkg::*;
#(
  parameter int CW    = 16,
  parameter int NPAIR = 4,
  localparam int NCMP = 2 * NPAIR,
  localparam int AW   = $clog2(NCMP + 6)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CW-1:0]    wr_data,
  output logic [NPAIR-1:0] wave_out,
  output logic [NCMP-1:0]  irq_flag
);
  logic [NCMP-1:0][CW-1:0] cmp_q;
  logic [CW-1:0]           per_q;
  rst_mode_e               mode_q;
  logic                    run_q;
  logic [NPAIR-1:0]        en_q, dflt_q, inv_q, act_q;
  logic [NCMP-1:0]         clr_mask, hit;
  logic [CW-1:0]           cnt_q;

  sc_regfile #(.CW(CW), .NPAIR(NPAIR)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_q(cmp_q), .per_q(per_q), .mode_q(mode_q), .run_q(run_q),
    .en_q(en_q), .dflt_q(dflt_q), .inv_q(inv_q), .clr_mask(clr_mask)
  );

  sc_base_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .mode(mode_q),
    .per(per_q), .cmp0(cmp_q[0]), .cnt_q(cnt_q)
  );

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic blk;
    assign blk = (g == 0) ? (mode_q == RM_CH0) : 1'b0;
    sc_pair_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .cnt(cnt_q), .run(run_q), .en(en_q[g]), .block(blk),
      .cmp_set(cmp_q[2*g]), .cmp_clr(cmp_q[2*g+1]),
      .dflt(dflt_q[g]), .inv(inv_q[g]),
      .hit_set(hit[2*g]), .hit_clr(hit[2*g+1]),
      .act_q(act_q[g]), .pin_q(wave_out[g])
    );
  end

  sc_flag_bank #(.NF(NCMP)) u_flags (
    .clk(clk), .rst(rst), .hit(hit), .clr_mask(clr_mask), .flag_q(irq_flag)
  );
endmodule

// File: rtl/setclr_wave_timer_chk.sv
module setclr_wave_timer_chk
  import setclr_pkg::*;
#(
  parameter int CW    = 16,
  parameter int NPAIR = 4,
  localparam int NCMP = 2 * NPAIR,
  localparam int AW   = $clog2(NCMP + 6)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [AW-1:0]           wr_addr,
  input logic [NCMP-1:0]         irq_flag,
  input logic [NPAIR-1:0]        wave_out,
  input logic [CW-1:0]           cnt,
  input logic                    run,
  input rst_mode_e               mode,
  input logic [CW-1:0]           per,
  input logic [NCMP-1:0][CW-1:0] cmp,
  input logic [NPAIR-1:0]        en,
  input logic [NPAIR-1:0]        dflt,
  input logic [NPAIR-1:0]        inv,
  input logic [NPAIR-1:0]        act
);
  // R6: without a clear write no flag may fall
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && wr_addr == AW'(NCMP + 5)) |->
      ((irq_flag & $past(irq_flag)) == $past(irq_flag)));

  // R1: free-running timer advances by one every clock, wrapping
  p_free_step_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && $past(run, 2) && $past(mode == RM_FREE) && $past(mode == RM_FREE, 2))
      |-> cnt == $past(cnt) + 1'b1);

  // R3: after reaching the period register, the timer is zero two clocks later
  p_per_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (run && mode == RM_PERIOD && cnt == per) ##1 run |=> cnt == '0);

  // R4: same rule with channel 0's set value as the clear point
  p_ch0_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (run && mode == RM_CH0 && cnt == cmp[0]) ##1 run |=> cnt == '0);

  for (genvar g = 0; g < NPAIR; g++) begin : g_pchk
    // R5: equal set and clear values leave the waveform untouched
    p_same_pt_r5: assert property (@(posedge clk) disable iff (rst)
      $past(run && en[g] && !(g == 0 && mode == RM_CH0) && cmp[2*g] == cmp[2*g+1])
        |-> act[g] == $past(act[g]));

    // R8: a disabled channel sits at resting level XOR inversion
    p_off_level_r8: assert property (@(posedge clk) disable iff (rst)
      $past(!en[g]) |-> wave_out[g] == $past(dflt[g] ^ inv[g]));
  end
endmodule

bind setclr_wave_timer setclr_wave_timer_chk #(.CW(CW), .NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .irq_flag(irq_flag),
  .wave_out(wave_out), .cnt(cnt_q), .run(run_q), .mode(mode_q), .per(per_q),
  .cmp(cmp_q), .en(en_q), .dflt(dflt_q), .inv(inv_q), .act(act_q)
);

// File: tb/setclr_wave_timer_test.sv
module setclr_wave_timer_test;
  localparam int CW = 8;
  localparam int NPAIR = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NPAIR-1:0] wave_out;
  logic [2*NPAIR-1:0] irq_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_a[NPAIR];
  int n_a[NPAIR];
  logic [NPAIR-1:0] on_v, dfl_v, inv_v;

  setclr_wave_timer #(.CW(CW), .NPAIR(NPAIR)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wave_out(wave_out), .irq_flag(irq_flag)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_addr = AW'(a);
    wr_data = CW'(d);
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic bit pair_act(input int c, input int m, input int n);
    return (m < n) && (c > m) && (c <= n);
  endfunction

  task automatic load_pairs();
    for (int g = 0; g < NPAIR; g++) begin
      wr(2*g, m_a[g]);
      wr(2*g+1, n_a[g]);
    end
    wr(10, int'(on_v));
    wr(11, int'(dfl_v));
    wr(12, int'(inv_v));
  endtask

  // Called at the negedge of cycle 0 (timer value 0); checks every cycle.
  task automatic sweep(input string tag, input int per, input int ncyc, input logic [NPAIR-1:0] blk);
    for (int t = 0; t < ncyc; t++) begin
      logic [NPAIR-1:0] e;
      for (int g = 0; g < NPAIR; g++)
        e[g] = ((on_v[g] && !blk[g] && pair_act(t % per, m_a[g], n_a[g])) ? 1'b1 : 1'b0)
               ^ dfl_v[g] ^ inv_v[g];
      chk(tag, 8'(wave_out), 8'(e));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 outputs", 8'(wave_out), 8'h00);
    chk("R10 flags", irq_flag, 8'h00);
    wr(0, 0);
    repeat (5) @(negedge clk);
    chk("R10 stopped no match", irq_flag, 8'h00);

    // R1 R2 R5: free-running sweep over two full periods
    m_a = '{10, 0, 100, 200};
    n_a = '{50, 255, 100, 201};
    on_v = 4'hF; dfl_v = 4'h0; inv_v = 4'h0;
    load_pairs();
    wr(9, 3'b100);
    sweep("R1/R2/R5 free-run", 256, 2*256 + 10, 4'h0);
    wr(9, 0);
    // R6: all compares were reached and stay set
    chk("R6 flags set", irq_flag, 8'hFF);
    wr(13, 8'hFE);
    chk("R6 write one keeps", irq_flag, 8'hFE);
    wr(13, 8'h00);
    chk("R6 write zero clears", irq_flag, 8'h00);

    // R7: clear coinciding with a match on flag 0; flag 1 matched earlier
    m_a = '{10, 200, 200, 200};
    n_a = '{5, 200, 200, 200};
    load_pairs();
    wr(9, 3'b100);
    repeat (10) @(negedge clk);
    wr(13, 8'h00);
    chk("R7 match beats clear", irq_flag, 8'h01);
    wr(9, 0);
    wr(13, 8'h00);
    chk("R6 cleared when stopped", irq_flag, 8'h00);

    // R3 R8 R9: period-register mode, p=40 -> period 42
    m_a = '{3, 5, 30, 12};
    n_a = '{7, 20, 41, 13};
    on_v = 4'b1110; dfl_v = 4'b1001; inv_v = 4'b1000;
    load_pairs();
    wr(8, 40);
    wr(9, 3'b101);
    sweep("R3/R8/R9 period reg", 42, 3*42 + 3, 4'h0);
    wr(9, 0);

    // R4 R5 R9: channel-0 clear mode, p=29 -> period 31, channel 0 held
    m_a = '{29, 3, 0, 8};
    n_a = '{5, 17, 30, 8};
    on_v = 4'hF; dfl_v = 4'b0000; inv_v = 4'b0011;
    load_pairs();
    wr(9, 3'b110);
    sweep("R4/R5/R9 ch0 clear", 31, 3*31 + 3, 4'b0001);
    wr(9, 0);

    // R8: disabling every channel gives resting level XOR inversion
    on_v = 4'h0; dfl_v = 4'b0101; inv_v = 4'b0110;
    wr(10, 0); wr(11, int'(dfl_v)); wr(12, int'(inv_v));
    wr(9, 3'b100);
    sweep("R8 disabled", 256, 40, 4'h0);
    wr(9, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule